// File: doc/BRIEF.md
# Block-Based SRAM Security Guard

This block sits between an AHB-Lite bus and a single-port internal SRAM. The SRAM is divided into equal blocks, and each block carries two attribute bits. One marks the block as secure or non-secure. The other marks it as privileged or open to unprivileged code. For every transfer the guard takes the block index from the address and compares the bus security signal (HNONSEC), the HPROT data/opcode bit and the HPROT privilege bit against that block's attributes. The transfer then has one of four outcomes:

- It is forwarded to the SRAM.
- It is silently absorbed: reads return zero and writes are dropped.
- It is flagged on a one-cycle illegal-access event line.
- It is answered with a two-cycle AHB ERROR response.

The rules are asymmetric. Non-secure code touching a secure block always raises the event. It also gets a bus error if it was fetching instructions. Secure code touching a non-secure block gets a bus error. A relax bit can make secure data reads and writes to non-secure blocks legal, but it never makes an instruction fetch legal. Privilege mismatches are absorbed without any event or error. When a transfer breaks both rules, the security rule decides the outcome.

The attribute masks and the relax bit live in a small register space on the same bus. Only secure, privileged transfers can change them. All transfers are word-wide.

Top module: `blk_mem_guard`

## Requirements
- R1: Address bit 12 set selects the register space, decoded by address bits 3:2. Offset 0x0 is control, with bit 0 the relax bit. Offset 0x4 is the secure mask, where bit n set means block n is secure. Offset 0x8 is the privilege mask, where bit n set means block n is privileged. After reset, relax reads 0 and both masks read all ones, so every block starts secure and privileged.
- R2: A non-secure data transfer (HPROT[0]=1) to a secure block reads zero, leaves the SRAM unchanged and completes OKAY. It raises illegal_evt_o for exactly one cycle, the first cycle of the data phase.
- R3: A non-secure instruction fetch (HPROT[0]=0) to a secure block raises illegal_evt_o and is answered with ERROR. The SRAM is not accessed.
- R4: With relax at 0, a secure transfer to a non-secure block is answered with ERROR, raises no event and leaves the SRAM unchanged.
- R5: With relax at 1, secure data reads and writes to a non-secure block are forwarded to the SRAM, provided the privilege rule allows them.
- R6: A secure instruction fetch from a non-secure block is answered with ERROR whatever the relax bit holds.
- R7: An unprivileged transfer (HPROT[1]=0) to a privileged block that passes the security rule reads zero, drops its write and completes OKAY with no event.
- R8: When a transfer breaks both the security rule and the privilege rule, the outcome (event, ERROR or silent absorption) is the one the security rule alone prescribes.
- R9: An ERROR response takes two data-phase cycles with HRESP high in both. HREADYOUT is low in the first cycle and high in the second.
- R10: A legal read returns the SRAM word after one wait state. A legal write stores HWDATA with no wait state. The block index is address bits 11:8 (256-byte blocks).
- R11: Only secure, privileged transfers can write or read the register space. Any other access to it reads zero, changes no register and completes OKAY with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | 13 | Byte address; bit 12 selects the register space |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | Write when high |
| hprot_i | input | 2 | Bit 0: data (1) / opcode (0); bit 1: privileged |
| hnonsec_i | input | 1 | High for a non-secure transfer |
| hwdata_i | input | 32 | Write data |
| hready_i | input | 1 | Bus ready (previous transfer complete) |
| hrdata_o | output | 32 | Read data |
| hreadyout_o | output | 1 | Slave ready |
| hresp_o | output | 1 | High for ERROR |
| illegal_evt_o | output | 1 | One-cycle illegal-access event |
| sram_req_o | output | 1 | SRAM access strobe |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | 10 | SRAM word address |
| sram_wdata_o | output | 32 | SRAM write data |
| sram_rdata_i | input | 32 | SRAM read data, one cycle after the strobe |

## Verification
The bench sets the four lowest blocks to every combination of secure and privileged attributes. It then drives every combination of security, fetch, privilege and direction at each of them, with the relax bit both clear and set. It predicts the response, the event, the wait-state count, the read data and the final SRAM contents arithmetically.

Each class of error shows up as a specific mismatch:
- A guard that lets relax legalise fetches would return OKAY for a secure fetch from a non-secure block.
- A guard that checks privilege first would absorb a non-secure, unprivileged fetch silently instead of raising the error and the event.
- An error sequence that is too short or too long would show a wait-state count other than one.

Register-space probing from non-secure or unprivileged transfers must leave the masks intact on read-back. A guard that accepts those writes would change how later transfers are judged.

// File: rtl/bmg_pkg.sv
package bmg_pkg;

  typedef enum logic [1:0] {
    VERD_PASS   = 2'd0,
    VERD_SILENT = 2'd1,
    VERD_ERROR  = 2'd2
  } verdict_e;

  typedef enum logic [3:0] {
    ST_IDLE = 4'd0,
    ST_WR   = 4'd1,
    ST_RD1  = 4'd2,
    ST_RD2  = 4'd3,
    ST_ZERO = 4'd4,
    ST_CFGW = 4'd5,
    ST_CFGR = 4'd6,
    ST_ERR1 = 4'd7,
    ST_ERR2 = 4'd8
  } dstate_e;

  localparam logic [1:0] CFG_CTRL = 2'd0;
  localparam logic [1:0] CFG_SEC  = 2'd1;
  localparam logic [1:0] CFG_PRIV = 2'd2;

endpackage

// File: rtl/bmg_rule.sv
module bmg_rule
  import bmg_pkg::*;
(
  input  logic     blk_sec_i,
  input  logic     blk_priv_i,
  input  logic     nonsec_i,
  input  logic     fetch_i,
  input  logic     priv_i,
  input  logic     relax_i,
  output verdict_e verdict_o,
  output logic     evt_o
);

  // security decides first, privilege only if security lets it through
  always_comb begin
    evt_o     = 1'b0;
    verdict_o = VERD_PASS;
    if (nonsec_i && blk_sec_i) begin
      evt_o     = 1'b1;
      verdict_o = fetch_i ? VERD_ERROR : VERD_SILENT;
    end else if (!nonsec_i && !blk_sec_i && (fetch_i || !relax_i)) begin
      verdict_o = VERD_ERROR;
    end else if (!priv_i && blk_priv_i) begin
      verdict_o = VERD_SILENT;
    end
  end

endmodule

// File: rtl/bmg_attr_regs.sv
module bmg_attr_regs
  import bmg_pkg::*;
#(
  parameter int unsigned NUM_BLK = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         sel_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_BLK-1:0] sec_mask_o,
  output logic [NUM_BLK-1:0] priv_mask_o,
  output logic               relax_o
);

  localparam int PAD = DATA_W - NUM_BLK;

  logic [NUM_BLK-1:0] sec_q, priv_q;
  logic               relax_q;
  logic [DATA_W-1:0]  sec_ext, priv_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q   <= '1;
      priv_q  <= '1;
      relax_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        CFG_CTRL: relax_q <= wr_data_i[0];
        CFG_SEC:  sec_q   <= wr_data_i[NUM_BLK-1:0];
        CFG_PRIV: priv_q  <= wr_data_i[NUM_BLK-1:0];
        default: ;
      endcase
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:NUM_BLK];
      assign sec_ext   = {{PAD{1'b0}}, sec_q};
      assign priv_ext  = {{PAD{1'b0}}, priv_q};
    end else begin : g_full
      assign sec_ext  = sec_q;
      assign priv_ext = priv_q;
    end
  endgenerate

  always_comb begin
    unique case (sel_i)
      CFG_CTRL: rd_data_o = {{(DATA_W-1){1'b0}}, relax_q};
      CFG_SEC:  rd_data_o = sec_ext;
      CFG_PRIV: rd_data_o = priv_ext;
      default:  rd_data_o = '0;
    endcase
  end

  assign sec_mask_o  = sec_q;
  assign priv_mask_o = priv_q;
  assign relax_o     = relax_q;

  // R11
  sec_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sec_q) |-> $past(wr_en_i));
  // R11
  priv_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(priv_q) |-> $past(wr_en_i));

endmodule

// File: rtl/bmg_dphase.sv
module bmg_dphase
  import bmg_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    accept_i,
  input  dstate_e kind_i,
  output dstate_e state_o,
  output logic    hreadyout_o,
  output logic    hresp_o
);

  dstate_e st_q, st_d;

  always_comb begin
    unique case (st_q)
      ST_RD1:  st_d = ST_RD2;
      ST_ERR1: st_d = ST_ERR2;
      default: st_d = accept_i ? kind_i : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o     = st_q;
  assign hreadyout_o = !((st_q == ST_RD1) || (st_q == ST_ERR1));
  assign hresp_o     = (st_q == ST_ERR1) || (st_q == ST_ERR2);

  // R9
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && !hreadyout_o) |=> (hresp_o && hreadyout_o));
  // R9
  err_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hresp_o && hreadyout_o) |-> $past(hresp_o && !hreadyout_o));

endmodule

// File: rtl/blk_mem_guard.sv
module blk_mem_guard
  import bmg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BLK_BYTES = 256,
  localparam int unsigned MEM_AW   = ADDR_W - 1,
  localparam int unsigned BYTE_LSB = $clog2(DATA_W / 8),
  localparam int unsigned WA_W     = MEM_AW - BYTE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [1:0]        hprot_i,
  input  logic              hnonsec_i,
  input  logic [DATA_W-1:0] hwdata_i,
  input  logic              hready_i,
  output logic [DATA_W-1:0] hrdata_o,
  output logic              hreadyout_o,
  output logic              hresp_o,
  output logic              illegal_evt_o,
  output logic              sram_req_o,
  output logic              sram_we_o,
  output logic [WA_W-1:0]   sram_addr_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  input  logic [DATA_W-1:0] sram_rdata_i
);

  localparam int unsigned BLK_LSB = $clog2(BLK_BYTES);
  localparam int unsigned IDX_W   = MEM_AW - BLK_LSB;
  localparam int unsigned NUM_BLK = 1 << IDX_W;

  logic               accept, is_cfg, fetch;
  logic [IDX_W-1:0]   blk_idx;
  logic [NUM_BLK-1:0] sec_mask, priv_mask;
  logic               relax, rule_evt;
  verdict_e           verdict;
  dstate_e            kind, st;
  logic [WA_W-1:0]    addr_q;
  logic [1:0]         sel_q;
  logic               evt_q;
  logic [DATA_W-1:0]  cfg_rd;
  logic               unused_bits;

  assign unused_bits = ^{haddr_i[BYTE_LSB-1:0], htrans_i[0]};

  assign accept  = hsel_i && htrans_i[1] && hready_i;
  assign is_cfg  = haddr_i[ADDR_W-1];
  assign blk_idx = haddr_i[MEM_AW-1:BLK_LSB];
  assign fetch   = !hprot_i[0];

  bmg_rule u_rule (
    .blk_sec_i (sec_mask[blk_idx]),
    .blk_priv_i(priv_mask[blk_idx]),
    .nonsec_i  (hnonsec_i),
    .fetch_i   (fetch),
    .priv_i    (hprot_i[1]),
    .relax_i   (relax),
    .verdict_o (verdict),
    .evt_o     (rule_evt)
  );

  always_comb begin
    if (is_cfg) begin
      if (!hnonsec_i && hprot_i[1]) kind = hwrite_i ? ST_CFGW : ST_CFGR;
      else                          kind = ST_ZERO;
    end else begin
      unique case (verdict)
        VERD_PASS:  kind = hwrite_i ? ST_WR : ST_RD1;
        VERD_ERROR: kind = ST_ERR1;
        default:    kind = ST_ZERO;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sel_q  <= '0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= accept && !is_cfg && rule_evt;
      if (accept) begin
        addr_q <= haddr_i[MEM_AW-1:BYTE_LSB];
        sel_q  <= haddr_i[BYTE_LSB+1:BYTE_LSB];
      end
    end
  end

  bmg_dphase u_dphase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .kind_i     (kind),
    .state_o    (st),
    .hreadyout_o(hreadyout_o),
    .hresp_o    (hresp_o)
  );

  bmg_attr_regs #(.NUM_BLK(NUM_BLK), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (st == ST_CFGW),
    .sel_i      (sel_q),
    .wr_data_i  (hwdata_i),
    .rd_data_o  (cfg_rd),
    .sec_mask_o (sec_mask),
    .priv_mask_o(priv_mask),
    .relax_o    (relax)
  );

  // writes go out in the data phase, reads one cycle later need a wait state
  assign sram_req_o   = (st == ST_WR) || (st == ST_RD1);
  assign sram_we_o    = (st == ST_WR);
  assign sram_addr_o  = addr_q;
  assign sram_wdata_o = hwdata_i;

  always_comb begin
    unique case (st)
      ST_RD2:  hrdata_o = sram_rdata_i;
      ST_CFGR: hrdata_o = cfg_rd;
      default: hrdata_o = '0;
    endcase
  end

  assign illegal_evt_o = evt_q;

  // R2
  evt_ns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_evt_o |-> $past(hnonsec_i && accept));
  // R2
  evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_evt_o && !hreadyout_o) |=> !illegal_evt_o);

endmodule

// File: tb/blk_mem_guard_bench.sv
module blk_mem_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [12:0] haddr = '0;
  logic [1:0]  htrans = '0;
  logic        hwrite = 1'b0;
  logic [1:0]  hprot = 2'b11;
  logic        hnonsec = 1'b0;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata_o;
  logic        hreadyout_o, hresp_o, illegal_evt_o;
  logic        sram_req_o, sram_we_o;
  logic [9:0]  sram_addr_o;
  logic [31:0] sram_wdata_o;
  logic [31:0] srd = '0;
  logic [31:0] mem [0:1023];

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  blk_mem_guard u_blk_mem_guard (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .haddr_i(haddr),
    .htrans_i(htrans), .hwrite_i(hwrite), .hprot_i(hprot),
    .hnonsec_i(hnonsec), .hwdata_i(hwdata), .hready_i(hreadyout_o),
    .hrdata_o(hrdata_o), .hreadyout_o(hreadyout_o), .hresp_o(hresp_o),
    .illegal_evt_o(illegal_evt_o), .sram_req_o(sram_req_o),
    .sram_we_o(sram_we_o), .sram_addr_o(sram_addr_o),
    .sram_wdata_o(sram_wdata_o), .sram_rdata_i(srd)
  );

  always @(posedge clk) begin
    if (sram_req_o && sram_we_o) mem[sram_addr_o] <= sram_wdata_o;
    if (sram_req_o && !sram_we_o) srd <= mem[sram_addr_o];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [12:0] a, input logic w, input logic [31:0] wd,
                      input logic ns, input logic [1:0] prot,
                      output logic [31:0] rd, output logic err,
                      output logic ev, output int lowcyc);
    @(negedge clk);
    hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = w; hprot = prot; hnonsec = ns;
    @(posedge clk); #1;
    hsel = 1'b0; htrans = 2'b00; hwdata = wd;
    @(negedge clk);
    ev = illegal_evt_o; err = 1'b0; lowcyc = 0;
    while (1) begin
      if (hresp_o) err = 1'b1;
      if (hreadyout_o) break;
      lowcyc++;
      @(negedge clk);
    end
    rd = hrdata_o;
  endtask

  function automatic int exp_v(bit s_blk, bit p_blk, bit ns, bit fetch, bit pv, bit rlx);
    if (ns && s_blk) return fetch ? 2 : 1;
    if (!ns && !s_blk && (fetch || !rlx)) return 2;
    if (!pv && p_blk) return 1;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic err, ev;
    int lc;
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h0001_0003) ^ 32'h5A5A_0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset hreadyout", {31'd0, hreadyout_o}, 32'd1);
    chk("R1 reset hresp", {31'd0, hresp_o}, 32'd0);
    chk("R1 reset event", {31'd0, illegal_evt_o}, 32'd0);

    xfer(13'h1000, 1'b0, 0, 1'b0, 2'b11, rd, err, ev, lc);
    chk("R1 ctrl reset", rd, 32'd0);
    xfer(13'h1004, 1'b0, 0, 1'b0, 2'b11, rd, err, ev, lc);
    chk("R1 secure mask reset", rd, 32'h0000_FFFF);
    xfer(13'h1008, 1'b0, 0, 1'b0, 2'b11, rd, err, ev, lc);
    chk("R1 priv mask reset", rd, 32'h0000_FFFF);

    // R11 probing from non-secure and unprivileged
    xfer(13'h1004, 1'b1, 32'h0, 1'b1, 2'b11, rd, err, ev, lc);
    chk("R11 ns write resp", {30'd0, err, ev}, 32'd0);
    xfer(13'h1008, 1'b1, 32'h0, 1'b0, 2'b01, rd, err, ev, lc);
    xfer(13'h1004, 1'b0, 0, 1'b0, 2'b01, rd, err, ev, lc);
    chk("R11 unpriv read zero", rd, 32'd0);
    xfer(13'h1004, 1'b0, 0, 1'b1, 2'b11, rd, err, ev, lc);
    chk("R11 ns read zero", rd, 32'd0);
    xfer(13'h1004, 1'b0, 0, 1'b0, 2'b11, rd, err, ev, lc);
    chk("R11 secure mask kept", rd, 32'h0000_FFFF);
    xfer(13'h1008, 1'b0, 0, 1'b0, 2'b11, rd, err, ev, lc);
    chk("R11 priv mask kept", rd, 32'h0000_FFFF);

    // blocks 0..3: (sec,priv) = 11, 01, 10, 00
    xfer(13'h1004, 1'b1, 32'h0000_FFF5, 1'b0, 2'b11, rd, err, ev, lc);
    xfer(13'h1008, 1'b1, 32'h0000_FFF3, 1'b0, 2'b11, rd, err, ev, lc);
    xfer(13'h1004, 1'b0, 0, 1'b0, 2'b11, rd, err, ev, lc);
    chk("R1 secure mask write", rd, 32'h0000_FFF5);

    for (int rlx = 0; rlx < 2; rlx++) begin
      xfer(13'h1000, 1'b1, rlx, 1'b0, 2'b11, rd, err, ev, lc);
      xfer(13'h1000, 1'b0, 0, 1'b0, 2'b11, rd, err, ev, lc);
      chk("R1 relax bit", rd, rlx);
      for (int b = 0; b < 4; b++) begin
        for (int code = 0; code < 16; code++) begin
          bit ns, fetch, pv, w, s_blk, p_blk, secv, privv;
          int v, exp_lc;
          logic [12:0] a;
          logic [31:0] wd, old;
          string tag;
          ns = code[3]; fetch = code[2]; pv = code[1]; w = code[0];
          s_blk = (b == 0) || (b == 2);
          p_blk = (b < 2);
          a = 13'(b * 256 + code * 4 + rlx * 64);
          wd = 32'hA500_0000 | (rlx << 12) | (b << 8) | code;
          old = mem[a[11:2]];
          v = exp_v(s_blk, p_blk, ns, fetch, pv, rlx[0]);
          secv = (ns && s_blk) || (!ns && !s_blk && (fetch || !rlx[0]));
          privv = !pv && p_blk;
          if (secv && privv) tag = "R8";
          else if (ns && s_blk) tag = fetch ? "R3" : "R2";
          else if (!ns && !s_blk && fetch) tag = "R6";
          else if (!ns && !s_blk && !rlx[0]) tag = "R4";
          else if (privv) tag = "R7";
          else if (!ns && !s_blk) tag = "R5";
          else tag = "R10";
          xfer(a, w, wd, ns, {pv, !fetch}, rd, err, ev, lc);
          chk({tag, " error response"}, {31'd0, err}, {31'd0, v == 2});
          chk({tag, " event"}, {31'd0, ev}, {31'd0, ns && s_blk});
          exp_lc = (v == 2 || (v == 0 && !w)) ? 1 : 0;
          chk({tag, (v == 2) ? " R9 error cycles" : " wait states"}, lc, exp_lc);
          if (v != 2 && !w) chk({tag, " read data"}, rd, (v == 0) ? old : 32'd0);
          if (w) begin
            @(posedge clk); #1;
            chk({tag, " sram after write"}, mem[a[11:2]], (v == 0) ? wd : old);
          end
        end
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule